// File: doc/BRIEF.md
# Twisted-Ring Sequencer with One-Hot Phase Decode

This block is a four-stage twisted-ring counter. The stages form a right-shifting chain, and the inverted output of the last stage is fed back into the first stage. Four flip-flops therefore step through eight distinct states before the pattern repeats. Every state is also decoded into one of eight phase lines. Each phase line is a two-input AND of two stage outputs, either adjacent stages or the two end stages, each taken true or inverted.

A controller uses the block to generate non-overlapping timing phases. It pulses the synchronous reset to start at phase 0, then holds the advance input high for each step it wants the sequence to move forward. While the advance input is low, the sequence stays where it is.

Top module: `phase_ring`

## Requirements
- R1: A clock edge with `rst` high sets `stageQ` to 4'b0000 and `phaseOut` to 8'b0000_0001.
- R2: At a clock edge, `rst` high takes priority over `advEn` high: the result is the R1 state.
- R3: At a clock edge with `rst` low and `advEn` low, `stageQ` and `phaseOut` keep their values.
- R4: At a clock edge with `rst` low and `advEn` high, `stageQ[0]` takes the inverse of the old `stageQ[3]`, and each `stageQ[i]` for i>0 takes the old `stageQ[i-1]`.
- R5: Starting from reset and advancing on every edge, `stageQ` goes through 0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000 (written as bit 3 down to bit 0) and then returns to 0000, so the period is 8.
- R6: `phaseOut[k]` is high exactly in the k-th state of the R5 list. With A=`stageQ[0]`, B=`stageQ[1]`, C=`stageQ[2]` and E=`stageQ[3]`, the terms are: 0 = !A&!E, 1 = A&!B, 2 = B&!C, 3 = C&!E, 4 = A&E, 5 = !A&B, 6 = !B&C, 7 = !C&E. Each advance moves the high line from k to (k+1) mod 8.
- R7: After reset, exactly one bit of `phaseOut` is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| advEn | input | 1 | Advance the sequence by one step at the clock edge |
| stageQ | output | 4 | Stage flip-flop outputs; bit 0 is the first stage |
| phaseOut | output | 8 | One-hot decoded phase lines |

## Verification
The one-hot and rotation assertions assume the register holds only states that reset and advancing can reach. The decode is correct only for the eight legal patterns, so this assumption matters. The stimulus therefore asserts reset before the first check and never forces the stages any other way. After that it mixes long runs of advancing (more than two full periods), single-cycle holds, longer holds, and reset applied both with and without `advEn` in the middle of a sequence.

// File: rtl/phase_ring_pkg.sv
package phase_ring_pkg;
  typedef struct packed {
    logic clear;
    logic advance;
  } ringStrobe_t;
endpackage

// File: rtl/phase_ring_ctrl.sv
module phase_ring_ctrl
  import phase_ring_pkg::*;
(
  input  logic        rst,
  input  logic        advEn,
  output ringStrobe_t strobe
);
  // Reset wins over advance (R2)
  always_comb begin
    strobe.clear   = rst;
    strobe.advance = advEn & ~rst;
  end
endmodule

// File: rtl/phase_ring_dp.sv
module phase_ring_dp
  import phase_ring_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic                  clk,
  input  ringStrobe_t           strobe,
  output logic [STAGES-1:0]     stageQ,
  output logic [2*STAGES-1:0]   phaseOut
);
  localparam int PHASES = 2 * STAGES;

  logic [STAGES-1:0] stageNext;

  // Twisted feedback into the first stage, plain shift elsewhere (R4)
  assign stageNext[0] = ~stageQ[STAGES-1];
  generate
    for (genvar i = 1; i < STAGES; i++) begin : gShift
      assign stageNext[i] = stageQ[i-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobe.clear)        stageQ <= '0;
    else if (strobe.advance) stageQ <= stageNext;
  end

  // Two-literal decode per phase (R6)
  generate
    for (genvar k = 0; k < PHASES; k++) begin : gDecode
      if (k == 0) begin : gFirstLow
        assign phaseOut[k] = ~stageQ[0] & ~stageQ[STAGES-1];
      end else if (k < STAGES) begin : gFillEdge
        assign phaseOut[k] = stageQ[k-1] & ~stageQ[k];
      end else if (k == STAGES) begin : gFirstHigh
        assign phaseOut[k] = stageQ[0] & stageQ[STAGES-1];
      end else begin : gDrainEdge
        assign phaseOut[k] = ~stageQ[k-STAGES-1] & stageQ[k-STAGES];
      end
    end
  endgenerate

  AST_CLEAR_ZERO: assert property (@(posedge clk) strobe.clear |=> (stageQ == '0)); // R1
  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (strobe.clear) !strobe.advance |=> $stable(stageQ)); // R3
  AST_TWIST_IN: assert property (@(posedge clk) disable iff (strobe.clear) strobe.advance |=> (stageQ[0] == !$past(stageQ[STAGES-1]))); // R4
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (strobe.clear) strobe.advance |=> (phaseOut == {$past(phaseOut[PHASES-2:0]), $past(phaseOut[PHASES-1])})); // R6
  AST_ONE_HOT: assert property (@(posedge clk) disable iff (strobe.clear) $countones(phaseOut) == 1); // R7
endmodule

// File: rtl/phase_ring.sv
module phase_ring
  import phase_ring_pkg::*;
#(
  parameter int STAGES = 4,
  localparam int PHASES = 2 * STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advEn,
  output logic [STAGES-1:0] stageQ,
  output logic [PHASES-1:0] phaseOut
);
  ringStrobe_t strobe;

  phase_ring_ctrl uCtrl (
    .rst   (rst),
    .advEn (advEn),
    .strobe(strobe)
  );

  phase_ring_dp #(.STAGES(STAGES)) uDp (
    .clk     (clk),
    .strobe  (strobe),
    .stageQ  (stageQ),
    .phaseOut(phaseOut)
  );
endmodule

// File: tb/phase_ring_test.sv
module phase_ring_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       advEn = 1'b0;
  logic [3:0] stageQ;
  logic [7:0] phaseOut;

  int checks = 0;
  int failures = 0;
  int refIdx = 0;

  phase_ring uut (
    .clk(clk), .rst(rst), .advEn(advEn),
    .stageQ(stageQ), .phaseOut(phaseOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] expStage(int idx);
    if (idx < 4) return 4'((1 << idx) - 1);
    return 4'(4'hF << (idx - 4));
  endfunction

  task automatic check(string tag);
    logic [3:0] es = expStage(refIdx);
    logic [7:0] ep = 8'(1 << refIdx);
    checks++;
    if (stageQ !== es) begin
      failures++;
      $display("FAIL %s stageQ actual=%b expected=%b", tag, stageQ, es);
    end
    checks++;
    if (phaseOut !== ep) begin
      failures++;
      $display("FAIL %s phaseOut actual=%b expected=%b", tag, phaseOut, ep);
    end
    checks++;
    if ($countones(phaseOut) != 1) begin
      failures++;
      $display("FAIL R7 phaseOut ones actual=%0d expected=1", $countones(phaseOut));
    end
  endtask

  // one clock: drive at negedge, reference update at posedge, compare at next negedge
  task automatic step(logic r, logic e, string tag);
    rst = r;
    advEn = e;
    @(posedge clk);
    if (r) refIdx = 0;
    else if (e) refIdx = (refIdx + 1) % 8;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b0, "R1");
    // three full periods, twist and sequence
    for (int i = 0; i < 24; i++) step(1'b0, 1'b1, (i < 8) ? "R5" : "R6");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R4");
    // single and long holds
    step(1'b0, 1'b0, "R3");
    step(1'b0, 1'b1, "R4");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, "R3");
    for (int i = 0; i < 10; i++) step(1'b0, (i % 2 == 0), "R6");
    // reset mid-sequence with advance high
    step(1'b1, 1'b1, "R2");
    step(1'b0, 1'b1, "R5");
    step(1'b0, 1'b1, "R5");
    step(1'b1, 1'b0, "R1");
    for (int i = 0; i < 17; i++) step(1'b0, (i % 3 != 2), "R7");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule